// File: doc/BRIEF.md
# Sectored Accumulator Instruction Executor

This block sequences a single-accumulator machine. Each instruction is a 13-bit syllable: a 4-bit opcode in the low bits and a 9-bit operand above it. Data words are 26 bits wide. The executor fetches one syllable per instruction from an external synchronous memory. It decodes the syllable and forms a full memory address from two sector registers. It then runs the load, store, add, subtract, reverse-subtract, AND, XOR, shift, set-data-sector and jump instructions against a 26-bit accumulator.

Memory is split into 256-word sectors. An instruction-sector register and an 8-bit word counter form the program counter. Data operands are found through the operand's top bit. That bit picks either the data sector chosen by software or the fixed residual sector 0. The low eight operand bits give the word inside that sector. An indirect jump reads a stored 26-bit constant that supplies both the new word and the new instruction sector.

The memory model registers its read: an address presented in one cycle returns its word in the next cycle. Every memory word is 26 bits. An instruction occupies the low 13 bits of its word. Multiply, divide, I/O, the execute-modify instruction, interrupts and parity checking are not part of this block. Their opcodes behave as no-ops.

Top module: `sector_acc_exec`

## Requirements
- R1: While reset is high and in the first cycle after it, the accumulator is 0, the program counter is 0, write enable is 0, and the data sector is 0. The data sector can be observed on the address of a later data access.
- R2: The program counter output is {instruction sector, 8-bit word}. A fetch presents this value on the memory address. Every instruction that does not branch advances the word by one, wrapping inside the sector. An instruction that reads a data operand takes 3 cycles, and every other instruction takes 2.
- R3: The opcode is syllable bits [3:0] and the operand is bits [12:4]. A data address is {sector, operand[7:0]}. The sector is 0 when operand bit 8 is 1, and the current data sector when operand bit 8 is 0.
- R4: Opcode 1111 loads the addressed word into the accumulator. Opcode 1011 asserts write enable for exactly one cycle, with the accumulator on write data, and leaves the accumulator unchanged.
- R5: Opcode 0111 adds memory to the accumulator. Opcode 0010 computes accumulator minus memory. Opcode 1101 computes memory minus accumulator. All three wrap modulo 2^26.
- R6: Opcode 0110 ANDs the accumulator with memory, and opcode 1001 XORs it with memory.
- R7: Opcode 1000 always jumps, opcode 0100 jumps when the accumulator is nonzero, and opcode 1100 jumps when accumulator bit 25 is 1. The target word is operand[7:0] in the current instruction sector, and operand bit 8 is ignored. A branch that is not taken advances the word by one.
- R8: Opcode 0000 reads the constant at the data address. The new word is constant bits [7:0], and the new instruction sector is constant bits [11:8].
- R9: Under opcode 1110, operand bits [1:0] select the operation: 01 shifts, 00 or 10 sets the data sector, and 11 is the execute-modify case. A set-data-sector instruction loads operand bits [5:2] into the data sector.
- R10: In the shift case, operand bits [3:2] give the amount and operand bit 4 gives the direction. Amount 0 clears the accumulator, 1 shifts by one, and 2 or 3 shifts by two. Direction 0 is an arithmetic right shift, and direction 1 is a left shift that fills with zeros.
- R11: The execute-modify case and opcodes 0001, 0011, 0101 and 1010 leave the accumulator and the sectors unchanged, write nothing, and advance the word by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 26 | Word returned by memory one cycle after its address |
| mem_addr | output | 12 | Memory address: {sector, word} |
| mem_wdata | output | 26 | Data to write |
| mem_we | output | 1 | Write enable for the current address |
| acc_o | output | 26 | Accumulator |
| pc_o | output | 12 | Program counter {instruction sector, word} |

## Verification
A wrong word counter or instruction sector shows up on the fetch address at the start of the next instruction. It also shows up on the program-counter output in the cycle the instruction retires. A corrupted data sector stays hidden until the next data access in that sector, and then that access's address is wrong in its second cycle. A wrong accumulator appears on its port as soon as the instruction retires. The bench's model follows each instruction cycle by cycle and compares the address, write enable, write data, accumulator and program counter in every cycle. Any divergence is therefore reported in the cycle where it first becomes visible.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    typedef enum logic [3:0] {
        OP_JIND  = 4'b0000,
        OP_RSV1  = 4'b0001,
        OP_SUB   = 4'b0010,
        OP_RSV3  = 4'b0011,
        OP_JNZ   = 4'b0100,
        OP_RSV5  = 4'b0101,
        OP_AND   = 4'b0110,
        OP_ADD   = 4'b0111,
        OP_JMP   = 4'b1000,
        OP_XOR   = 4'b1001,
        OP_RSVA  = 4'b1010,
        OP_STORE = 4'b1011,
        OP_JNEG  = 4'b1100,
        OP_RSUB  = 4'b1101,
        OP_MISC  = 4'b1110,
        OP_LOAD  = 4'b1111
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_LOAD,
        ALU_ADD,
        ALU_SUB,
        ALU_RSUB,
        ALU_AND,
        ALU_XOR
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DEC,
        ST_EXEC
    } state_e;

    typedef struct packed {
        logic    reads_mem;
        logic    writes_mem;
        logic    jump;
        logic    indirect;
        logic    shift;
        logic    setsec;
        alu_op_e alu_op;
    } dec_t;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
    import acc_exec_pkg::*;
(
    input  logic [3:0] opcode,
    input  logic [1:0] sub_sel,
    input  logic       acc_zero,
    input  logic       acc_neg,
    output dec_t       dec
);

    always_comb begin
        dec        = '0;
        dec.alu_op = ALU_LOAD;
        case (opcode_e'(opcode))
            OP_JIND: begin
                dec.reads_mem = 1'b1;
                dec.indirect  = 1'b1;
            end
            OP_SUB: begin
                dec.reads_mem = 1'b1;
                dec.alu_op    = ALU_SUB;
            end
            OP_JNZ:  dec.jump = !acc_zero;
            OP_AND: begin
                dec.reads_mem = 1'b1;
                dec.alu_op    = ALU_AND;
            end
            OP_ADD: begin
                dec.reads_mem = 1'b1;
                dec.alu_op    = ALU_ADD;
            end
            OP_JMP:  dec.jump = 1'b1;
            OP_XOR: begin
                dec.reads_mem = 1'b1;
                dec.alu_op    = ALU_XOR;
            end
            OP_STORE: dec.writes_mem = 1'b1;
            OP_JNEG:  dec.jump = acc_neg;
            OP_RSUB: begin
                dec.reads_mem = 1'b1;
                dec.alu_op    = ALU_RSUB;
            end
            OP_MISC: begin
                if (sub_sel == 2'b01) begin
                    dec.shift = 1'b1;
                end else if (sub_sel[0] == 1'b0) begin
                    dec.setsec = 1'b1;
                end
            end
            OP_LOAD: begin
                dec.reads_mem = 1'b1;
                dec.alu_op    = ALU_LOAD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_exec_addr.sv
module acc_exec_addr #(
    parameter int SECT_W = 4,
    parameter int WORD_W = 8
) (
    input  logic [WORD_W:0]             opnd,
    input  logic [SECT_W-1:0]           dsec,
    output logic [SECT_W+WORD_W-1:0]    daddr
);

    localparam logic [SECT_W-1:0] RESID_SECT = '0;

    logic [SECT_W-1:0] sect;

    always_comb begin
        sect  = opnd[WORD_W] ? RESID_SECT : dsec;
        daddr = {sect, opnd[WORD_W-1:0]};
    end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 26
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        case (op)
            ALU_ADD:  res = acc + mem;
            ALU_SUB:  res = acc - mem;
            ALU_RSUB: res = mem - acc;
            ALU_AND:  res = acc & mem;
            ALU_XOR:  res = acc ^ mem;
            default:  res = mem;
        endcase
    end

endmodule

// File: rtl/acc_exec_shift.sv
module acc_exec_shift #(
    parameter int DATA_W = 26
) (
    input  logic [DATA_W-1:0] val,
    input  logic [1:0]        amt,
    input  logic              left,
    output logic [DATA_W-1:0] res
);

    localparam int TOP = DATA_W - 1;

    always_comb begin
        case (amt)
            2'd0:    res = '0;
            2'd1:    res = left ? {val[TOP-1:0], 1'b0}
                                : {val[TOP], val[TOP:1]};
            default: res = left ? {val[TOP-2:0], 2'b00}
                                : {{2{val[TOP]}}, val[TOP:2]};
        endcase
    end

endmodule

// File: rtl/sector_acc_exec.sv
module sector_acc_exec
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 26,
    parameter int WORD_W = 8,
    parameter int SECT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [SECT_W+WORD_W-1:0] mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     mem_we,
    output logic [DATA_W-1:0]        acc_o,
    output logic [SECT_W+WORD_W-1:0] pc_o
);

    localparam int OPC_W  = 4;
    localparam int OPND_W = WORD_W + 1;
    localparam int SYL_W  = OPC_W + OPND_W;
    localparam int SEC_LO = 2;

    typedef struct packed {
        state_e              state;
        logic [DATA_W-1:0]   acc;
        logic [WORD_W-1:0]   pc;
        logic [SECT_W-1:0]   isec;
        logic [SECT_W-1:0]   dsec;
        logic [SYL_W-1:0]    ir;
    } regs_t;

    regs_t q, d;

    logic [SYL_W-1:0]         instr;
    logic [OPND_W-1:0]        opnd;
    dec_t                     dec;
    logic [SECT_W+WORD_W-1:0] daddr;
    logic [DATA_W-1:0]        alu_res;
    logic [DATA_W-1:0]        shf_res;
    logic [WORD_W-1:0]        pc_inc;

    // The syllable comes straight from memory in the decode cycle.
    assign instr  = (q.state == ST_DEC) ? mem_rdata[SYL_W-1:0] : q.ir;
    assign opnd   = instr[SYL_W-1:OPC_W];
    assign pc_inc = q.pc + WORD_W'(1);

    acc_exec_decode u_dec (
        .opcode   (instr[OPC_W-1:0]),
        .sub_sel  (opnd[1:0]),
        .acc_zero (q.acc == '0),
        .acc_neg  (q.acc[DATA_W-1]),
        .dec      (dec)
    );

    acc_exec_addr #(.SECT_W(SECT_W), .WORD_W(WORD_W)) u_addr (
        .opnd  (opnd),
        .dsec  (q.dsec),
        .daddr (daddr)
    );

    acc_exec_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (dec.alu_op),
        .acc (q.acc),
        .mem (mem_rdata),
        .res (alu_res)
    );

    acc_exec_shift #(.DATA_W(DATA_W)) u_shf (
        .val  (q.acc),
        .amt  (opnd[3:2]),
        .left (opnd[4]),
        .res  (shf_res)
    );

    always_comb begin
        d         = q;
        mem_addr  = {q.isec, q.pc};
        mem_we    = 1'b0;
        mem_wdata = q.acc;
        case (q.state)
            ST_FETCH: d.state = ST_DEC;
            ST_DEC: begin
                d.ir    = instr;
                d.state = ST_FETCH;
                if (dec.reads_mem) begin
                    mem_addr = daddr;
                    d.state  = ST_EXEC;
                end else if (dec.writes_mem) begin
                    mem_addr = daddr;
                    mem_we   = 1'b1;
                    d.pc     = pc_inc;
                end else if (dec.jump) begin
                    d.pc = opnd[WORD_W-1:0];
                end else begin
                    d.pc = pc_inc;
                    if (dec.shift) begin
                        d.acc = shf_res;
                    end
                    if (dec.setsec) begin
                        d.dsec = opnd[SEC_LO +: SECT_W];
                    end
                end
            end
            ST_EXEC: begin
                d.state = ST_FETCH;
                if (dec.indirect) begin
                    d.pc   = mem_rdata[WORD_W-1:0];
                    d.isec = mem_rdata[WORD_W +: SECT_W];
                end else begin
                    d.acc = alu_res;
                    d.pc  = pc_inc;
                end
            end
            default: d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc;
    assign pc_o  = {q.isec, q.pc};

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
    parameter int DATA_W = 26,
    parameter int AW     = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] acc_o,
    input logic [AW-1:0]     pc_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_o == '0 && pc_o == '0 && !mem_we));

    // R4
    store_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R4
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(acc_o));

    // R2
    pc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_o) |=> $stable(pc_o));

    // R5
    acc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_o) |=> $stable(acc_o));

endmodule

bind sector_acc_exec acc_exec_chk #(
    .DATA_W (DATA_W),
    .AW     (SECT_W + WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .acc_o    (acc_o),
    .pc_o     (pc_o)
);

// File: tb/tb_sector_acc_exec.sv
module tb_sector_acc_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [25:0] mem_rdata = '0;
    logic [11:0] mem_addr;
    logic [25:0] mem_wdata;
    logic        mem_we;
    logic [25:0] acc_o;
    logic [11:0] pc_o;

    int checks = 0;
    int errors = 0;

    logic [25:0] mem     [0:4095];
    logic [25:0] ref_mem [0:4095];

    logic [25:0] r_acc;
    logic [7:0]  r_pc;
    logic [3:0]  r_isec;
    logic [3:0]  r_dsec;

    always #2 clk = ~clk;

    sector_acc_exec dut (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc_o     (acc_o),
        .pc_o      (pc_o)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [25:0] mk(input logic [3:0] op, input logic [8:0] opnd);
        return {13'h0, opnd, op};
    endfunction

    function automatic logic [8:0] res_w(input logic [7:0] w);
        return {1'b1, w};
    endfunction

    task automatic put(input int a, input logic [25:0] v);
        mem[a]     = v;
        ref_mem[a] = v;
    endtask

    // One instruction: model computes results, then compare every cycle.
    task automatic run_one();
        logic [11:0] cur, ea;
        logic [12:0] ins;
        logic [3:0]  op;
        logic [8:0]  opnd;
        logic [25:0] mv, n_acc;
        logic [7:0]  n_pc;
        logic [3:0]  n_isec, n_dsec;
        logic signed [25:0] sv;
        int ncyc;
        int amt;
        bit is_rd, is_st;
        string tag;
        cur  = {r_isec, r_pc};
        ins  = ref_mem[cur][12:0];
        op   = ins[3:0];
        opnd = ins[12:4];
        ea   = {opnd[8] ? 4'h0 : r_dsec, opnd[7:0]};
        mv   = ref_mem[ea];
        n_acc = r_acc; n_pc = r_pc + 8'd1; n_isec = r_isec; n_dsec = r_dsec;
        is_rd = 1'b0; is_st = 1'b0; ncyc = 2; tag = "R11";
        case (op)
            4'b1111: begin is_rd = 1; n_acc = mv; tag = "R4"; end
            4'b1011: begin is_st = 1; tag = "R4"; end
            4'b0111: begin is_rd = 1; n_acc = r_acc + mv; tag = "R5"; end
            4'b0010: begin is_rd = 1; n_acc = r_acc - mv; tag = "R5"; end
            4'b1101: begin is_rd = 1; n_acc = mv - r_acc; tag = "R5"; end
            4'b0110: begin is_rd = 1; n_acc = r_acc & mv; tag = "R6"; end
            4'b1001: begin is_rd = 1; n_acc = r_acc ^ mv; tag = "R6"; end
            4'b1000: begin n_pc = opnd[7:0]; tag = "R7"; end
            4'b0100: begin if (r_acc != 0) n_pc = opnd[7:0]; tag = "R7"; end
            4'b1100: begin if (r_acc[25]) n_pc = opnd[7:0]; tag = "R7"; end
            4'b0000: begin
                is_rd = 1; n_pc = mv[7:0]; n_isec = mv[11:8]; tag = "R8";
            end
            4'b1110: begin
                if (opnd[1:0] == 2'b01) begin
                    tag = "R10";
                    amt = int'(opnd[3:2]);
                    if (amt == 0) n_acc = '0;
                    else begin
                        if (amt == 3) amt = 2;
                        sv = r_acc;
                        n_acc = opnd[4] ? (r_acc << amt) : 26'(sv >>> amt);
                    end
                end else if (opnd[0] == 1'b0) begin
                    tag = "R9";
                    n_dsec = opnd[5:2];
                end else tag = "R11";
            end
            default: tag = "R11";
        endcase
        if (is_rd) ncyc = 3;
        // Fetch cycle: address is the program counter (R2)
        chk("R2", "fetch address", 32'(mem_addr), 32'(cur));
        chk(tag, "write enable idle", 32'(mem_we), 0);
        for (int c = 1; c <= ncyc; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1 && (is_rd || is_st))
                chk("R3", "data address", 32'(mem_addr), 32'(ea));
            if (c == 1)
                chk(is_st ? "R4" : tag, "write enable", 32'(mem_we), 32'(is_st));
            if (c == 1 && is_st)
                chk("R4", "write data", 32'(mem_wdata), 32'(r_acc));
            if (c < ncyc) begin
                chk(tag, "acc held", 32'(acc_o), 32'(r_acc));
                chk("R2", "pc held", 32'(pc_o), 32'({r_isec, r_pc}));
            end else begin
                chk(tag, "acc result", 32'(acc_o), 32'(n_acc));
                chk(tag, "pc result", 32'(pc_o), 32'({n_isec, n_pc}));
            end
        end
        if (is_st) begin
            ref_mem[ea] = r_acc;
            chk("R4", "stored word", 32'(mem[ea]), 32'(r_acc));
        end
        r_acc = n_acc; r_pc = n_pc; r_isec = n_isec; r_dsec = n_dsec;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) put(i, 26'h0);
        // residual-sector constants
        put(12'h080, 26'h1234567);
        put(12'h081, 26'h3FFFFFF);
        put(12'h082, 26'h2345678);
        put(12'h083, 26'h0F0F0F0);
        put(12'h084, 26'h3C3C3C3);
        put(12'h085, 26'h15A5A5A);
        put(12'h086, 26'h00002FE);     // R8: sector 2, word FE
        put(12'h311, 26'h2000003);
        put(12'h120, 26'h3000000);
        // program, sector 0
        put(0,  mk(4'b1111, res_w(8'h80)));   // R4 load
        put(1,  mk(4'b0111, res_w(8'h81)));   // R5 add with wrap
        put(2,  mk(4'b1011, 9'h090));         // R1 data sector 0 -> 0x090
        put(3,  mk(4'b0010, res_w(8'h82)));   // R5 sub, goes negative
        put(4,  mk(4'b1100, 9'h106));         // R7 jneg taken, bit 8 ignored
        put(5,  mk(4'b1111, res_w(8'h80)));
        put(6,  mk(4'b1101, res_w(8'h83)));   // R5 reverse sub
        put(7,  mk(4'b0110, res_w(8'h84)));   // R6 and
        put(8,  mk(4'b1001, res_w(8'h85)));   // R6 xor
        put(9,  mk(4'b1110, 9'h00C));         // R9 sector 3, sel 00
        put(10, mk(4'b1011, 9'h010));         // R3 store to 0x310
        put(11, mk(4'b1111, 9'h011));         // R3 load 0x311
        put(12, mk(4'b1110, 9'h005));         // R10 right 1 arithmetic
        put(13, mk(4'b1110, 9'h019));         // R10 left 2
        put(14, mk(4'b1110, 9'h00D));         // R10 amount 3 -> 2 right
        put(15, mk(4'b1110, 9'h0F3));         // R11 execute-modify no-op
        put(16, mk(4'b0001, 9'h180));         // R11 reserved
        put(17, mk(4'b0011, 9'h010));
        put(18, mk(4'b0101, 9'h010));
        put(19, mk(4'b1010, 9'h010));
        put(20, mk(4'b1110, 9'h006));         // R9 sector 1, sel 10
        put(21, mk(4'b1111, 9'h020));         // load 0x120
        put(22, mk(4'b0100, 9'h019));         // R7 jnz taken -> 25
        put(23, mk(4'b1111, res_w(8'h80)));
        put(24, mk(4'b1111, res_w(8'h80)));
        put(25, mk(4'b1110, 9'h001));         // R10 amount 0 clears
        put(26, mk(4'b0100, 9'h017));         // R7 jnz not taken
        put(27, mk(4'b1100, 9'h017));         // R7 jneg not taken
        put(28, mk(4'b1000, 9'h01E));         // R7 jmp -> 30
        put(29, mk(4'b1111, res_w(8'h80)));
        put(30, mk(4'b0000, res_w(8'h86)));   // R8 indirect jump
        put(12'h2FE, mk(4'b0111, res_w(8'h80)));
        put(12'h2FF, mk(4'b1011, res_w(8'h91))); // R2 wrap to 0x200
        put(12'h200, mk(4'b1000, 9'h000));   // self loop

        r_acc = '0; r_pc = '0; r_isec = '0; r_dsec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset acc", 32'(acc_o), 0);
        chk("R1", "reset pc", 32'(pc_o), 0);
        chk("R1", "reset write enable", 32'(mem_we), 0);
        rst = 1'b0;
        for (int k = 0; k < 34; k++) run_one();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule